// File: doc/BRIEF.md
# Timer/Counter with Shared Prescaler

This block is an 8-bit up-counting timer whose count events come either from an internal instruction-cycle tick or from edges on an external input pin. A single programmable power-of-two prescaler sits between the event sources and their consumers. Configuration assigns it to one of two owners: the timer, or a watchdog time base that arrives as a tick input. The consumer that does not own the prescaler receives its events undivided.

A configuration byte chooses the event source, the active edge of the external pin, the prescaler owner and a 3-bit rate code. The same rate code gives a ratio one power of two larger when the timer owns the prescaler than when the watchdog owns it. Software can load the timer through a write port. When the timer rolls over from 0xFF to 0x00 it sets an overflow flag. That flag and its interrupt enable live in a control byte that has its own write port.

Top module: `tps_timer_top`

## Requirements
- R1: While rstN is low, timerVal, ovfFlag, ovfEnable and the prescaler count are all zero.
- R2: The cfgByte fields are as follows. Bits [2:0] hold the rate code, bit 3 selects the owner (0 timer, 1 watchdog), bit 4 selects the edge (0 rising, 1 falling) and bit 5 selects the source (0 cycleTick, 1 extPin). Bits 7 and 6 have no effect.
- R3: With the timer as owner, the timer advances once per 2^(code+1) source events. A prescaler count that is already at or above the terminal value wraps to zero on the next event and produces a step.
- R4: With the watchdog as owner, wdtStep pulses once per 2^code wdtBaseTick pulses (code 000 passes every tick), and the timer advances on every source event.
- R5: With the timer as owner, wdtStep equals wdtBaseTick in the same cycle.
- R6: With source 0, the timer counts clock cycles in which cycleTick is high. With source 1, it counts edges on extPin, and cycleTick has no effect.
- R7: extPin goes through a two-flop synchronizer. A qualifying edge is counted at the third rising clock edge after the pin changes, and only the selected edge direction is counted.
- R8: A cycle with timerWrEn high loads timerWrData into the timer and does not increment it. When the timer owns the prescaler, the same write also clears the prescaler count.
- R9: An increment from 0xFF gives 0x00 and sets ovfFlag. The flag stays set until it is written. If a rollover and a flag write happen in the same cycle, the set wins.
- R10: A cycle with flagWrEn high writes flagWrData bit 2 into ovfFlag and flagWrData bit 5 into ovfEnable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extPin | input | 1 | External count pin (asynchronous) |
| cycleTick | input | 1 | Internal instruction-cycle tick |
| wdtBaseTick | input | 1 | Watchdog time-base tick |
| cfgByte | input | 8 | Configuration byte |
| timerWrEn | input | 1 | Timer load strobe |
| timerWrData | input | 8 | Timer load value |
| flagWrEn | input | 1 | Interrupt-control write strobe |
| flagWrData | input | 8 | Interrupt-control write value |
| timerVal | output | 8 | Current timer value |
| ovfFlag | output | 1 | Timer overflow flag |
| ovfEnable | output | 1 | Overflow interrupt enable |
| wdtStep | output | 1 | Watchdog count step |

## Verification
The hardest case to reach is a timer write that lands while the prescaler holds a partial count. Its effect only shows up several source events later, as an earlier or later timer step. The stimulus handles this by leaving the prescaler part-way through a 1:4 ratio and writing the timer in the next cycle. It also places a rollover in the same cycle as a clearing flag write, and it switches the edge direction while the synchronized pin level is stable. A behavioural model checked on every clock catches any step that arrives one event early or late.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int RATE_W  = 3;
  localparam int SHIFT_W = RATE_W + 1;

  typedef struct packed {
    logic               srcEvt;
    logic               wdtEvt;
    logic               asgWdt;
    logic [SHIFT_W-1:0] shift;
    logic               tmrLoad;
    logic               preClr;
    logic               flagWr;
  } tpsStrobe_t;
endpackage

// File: rtl/tps_ctrl.sv
module tps_ctrl
  import tps_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CFG_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extPin,
  input  logic             cycleTick,
  input  logic             wdtBaseTick,
  input  logic [CFG_W-1:0] cfgByte,
  input  logic             timerWrEn,
  input  logic             flagWrEn,
  output tpsStrobe_t       strb
);
  localparam int ASG_BIT  = RATE_W;
  localparam int EDGE_BIT = RATE_W + 1;
  localparam int SRC_BIT  = RATE_W + 2;

  logic [SYNC_STAGES-1:0] syncQ;
  logic pinPrev;
  logic pinNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      pinPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], extPin};
      pinPrev <= pinNow;
    end
  end

  assign pinNow = syncQ[SYNC_STAGES-1];

  logic [RATE_W-1:0] rateCode;
  logic asgWdt, edgeFall, srcExt, extEvt;

  always_comb begin
    rateCode = cfgByte[RATE_W-1:0];
    asgWdt   = cfgByte[ASG_BIT];
    edgeFall = cfgByte[EDGE_BIT];
    srcExt   = cfgByte[SRC_BIT];
    extEvt   = edgeFall ? (pinPrev & ~pinNow) : (pinNow & ~pinPrev);

    strb.srcEvt  = srcExt ? extEvt : cycleTick;
    strb.wdtEvt  = wdtBaseTick;
    strb.asgWdt  = asgWdt;
    strb.shift   = SHIFT_W'(rateCode) + (asgWdt ? SHIFT_W'(0) : SHIFT_W'(1));
    strb.tmrLoad = timerWrEn;
    strb.preClr  = timerWrEn & ~asgWdt;
    strb.flagWr  = flagWrEn;
  end
endmodule

// File: rtl/tps_dpath.sv
module tps_dpath
  import tps_pkg::*;
#(
  parameter int TMR_W    = 8,
  parameter int PRE_W    = 8,
  parameter int FLAG_BIT = 2,
  parameter int EN_BIT   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  tpsStrobe_t       strb,
  input  logic [TMR_W-1:0] timerWrData,
  input  logic [7:0]       flagWrData,
  output logic [TMR_W-1:0] timerVal,
  output logic             ovfFlag,
  output logic             ovfEnable,
  output logic             wdtStep
);
  localparam logic [TMR_W-1:0] TMR_MAX = '1;

  logic [PRE_W-1:0] preCnt, preTerm;
  logic preEvt, preHit, tmrStep, rollOver;

  always_comb begin
    preTerm  = (PRE_W'(1) << strb.shift) - PRE_W'(1);
    preEvt   = strb.asgWdt ? strb.wdtEvt : strb.srcEvt;
    preHit   = preEvt && (preCnt >= preTerm);
    tmrStep  = strb.asgWdt ? strb.srcEvt : preHit;
    wdtStep  = strb.asgWdt ? preHit : strb.wdtEvt;
    rollOver = tmrStep && !strb.tmrLoad && (timerVal == TMR_MAX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            preCnt <= '0;
    else if (strb.preClr) preCnt <= '0;
    else if (preEvt)      preCnt <= preHit ? '0 : preCnt + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             timerVal <= '0;
    else if (strb.tmrLoad) timerVal <= timerWrData;
    else if (tmrStep)      timerVal <= timerVal + TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag   <= 1'b0;
      ovfEnable <= 1'b0;
    end else begin
      if (rollOver)         ovfFlag <= 1'b1;
      else if (strb.flagWr) ovfFlag <= flagWrData[FLAG_BIT];
      if (strb.flagWr)      ovfEnable <= flagWrData[EN_BIT];
    end
  end
endmodule

// File: rtl/tps_timer_top.sv
module tps_timer_top
  import tps_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extPin,
  input  logic             cycleTick,
  input  logic             wdtBaseTick,
  input  logic [7:0]       cfgByte,
  input  logic             timerWrEn,
  input  logic [TMR_W-1:0] timerWrData,
  input  logic             flagWrEn,
  input  logic [7:0]       flagWrData,
  output logic [TMR_W-1:0] timerVal,
  output logic             ovfFlag,
  output logic             ovfEnable,
  output logic             wdtStep
);
  tpsStrobe_t strb;

  tps_ctrl #(.SYNC_STAGES(2), .CFG_W(8)) u_ctrl (
    .clk(clk), .rstN(rstN), .extPin(extPin), .cycleTick(cycleTick),
    .wdtBaseTick(wdtBaseTick), .cfgByte(cfgByte), .timerWrEn(timerWrEn),
    .flagWrEn(flagWrEn), .strb(strb)
  );

  tps_dpath #(.TMR_W(TMR_W), .PRE_W(8)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .timerWrData(timerWrData),
    .flagWrData(flagWrData), .timerVal(timerVal), .ovfFlag(ovfFlag),
    .ovfEnable(ovfEnable), .wdtStep(wdtStep)
  );
endmodule

// File: rtl/tps_chk.sv
module tps_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cycleTick,
  input logic       wdtBaseTick,
  input logic [7:0] cfgByte,
  input logic       timerWrEn,
  input logic [7:0] timerWrData,
  input logic       flagWrEn,
  input logic [7:0] flagWrData,
  input logic [7:0] timerVal,
  input logic       ovfFlag,
  input logic       ovfEnable,
  input logic       wdtStep
);
  // R8
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    timerWrEn |=> timerVal == $past(timerWrData));

  // R9
  rollover_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!timerWrEn && timerVal == 8'hFF) ##1 (timerVal == 8'h00) |-> ovfFlag);

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !timerWrEn |=> (timerVal == $past(timerVal)) || (timerVal == $past(timerVal) + 8'd1));

  // R4
  direct_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgByte[3] && !cfgByte[5] && cycleTick && !timerWrEn) |=> timerVal == $past(timerVal) + 8'd1);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgByte[5] && !cycleTick && !timerWrEn) |=> $stable(timerVal));

  // R10
  enable_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagWrEn |=> ovfEnable == $past(flagWrData[5]));

  // R5
  wdt_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgByte[3] |-> wdtStep == wdtBaseTick);
endmodule

bind tps_timer_top tps_chk u_chk (
  .clk(clk), .rstN(rstN), .cycleTick(cycleTick), .wdtBaseTick(wdtBaseTick),
  .cfgByte(cfgByte), .timerWrEn(timerWrEn), .timerWrData(timerWrData),
  .flagWrEn(flagWrEn), .flagWrData(flagWrData), .timerVal(timerVal),
  .ovfFlag(ovfFlag), .ovfEnable(ovfEnable), .wdtStep(wdtStep)
);

// File: tb/test_tps_timer_top.sv
`timescale 1ns/1ps
module test_tps_timer_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extPin = 1'b0, cycleTick = 1'b0, wdtBaseTick = 1'b0;
  logic [7:0] cfgByte = 8'h00;
  logic timerWrEn = 1'b0, flagWrEn = 1'b0;
  logic [7:0] timerWrData = 8'h00, flagWrData = 8'h00;
  logic [7:0] timerVal;
  logic ovfFlag, ovfEnable, wdtStep;

  int checks = 0, errors = 0;
  string curReq = "R1";

  // behavioural reference state
  int mTmr = 0, mPc = 0, mS1 = 0, mS2 = 0, mPrev = 0;
  bit mFlag = 0, mEn = 0;
  int wdtSeen = 0;

  always #5 clk = ~clk;

  tps_timer_top i_tps_timer_top (
    .clk(clk), .rstN(rstN), .extPin(extPin), .cycleTick(cycleTick),
    .wdtBaseTick(wdtBaseTick), .cfgByte(cfgByte), .timerWrEn(timerWrEn),
    .timerWrData(timerWrData), .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .timerVal(timerVal), .ovfFlag(ovfFlag), .ovfEnable(ovfEnable), .wdtStep(wdtStep)
  );

  function automatic int termOf();
    int sh = int'(cfgByte[2:0]) + (cfgByte[3] ? 0 : 1);
    return (1 << sh) - 1;
  endfunction

  function automatic bit expWdt();
    if (!cfgByte[3]) return wdtBaseTick;
    return wdtBaseTick && (mPc >= termOf());
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mTmr = 0; mPc = 0; mS1 = 0; mS2 = 0; mPrev = 0; mFlag = 0; mEn = 0;
    end else begin
      bit extEv, src, pEv, hit, step, ovf;
      int term;
      extEv = cfgByte[4] ? (mS2 == 0 && mPrev == 1) : (mS2 == 1 && mPrev == 0);
      mPrev = mS2; mS2 = mS1; mS1 = int'(extPin);
      src  = cfgByte[5] ? extEv : cycleTick;
      term = termOf();
      pEv  = cfgByte[3] ? wdtBaseTick : src;
      hit  = pEv && (mPc >= term);
      step = cfgByte[3] ? src : hit;
      if (timerWrEn && !cfgByte[3]) mPc = 0;
      else if (pEv) mPc = hit ? 0 : mPc + 1;
      ovf = 0;
      if (timerWrEn) mTmr = int'(timerWrData);
      else if (step) begin
        if (mTmr == 255) begin mTmr = 0; ovf = 1; end
        else mTmr = mTmr + 1;
      end
      if (ovf) mFlag = 1;
      else if (flagWrEn) mFlag = flagWrData[2];
      if (flagWrEn) mEn = flagWrData[5];
    end
  end

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      chk(int'(timerVal), mTmr, "timerVal");
      chk(int'(ovfFlag), int'(mFlag), "ovfFlag");
      chk(int'(ovfEnable), int'(mEn), "ovfEnable");
      chk(int'(wdtStep), int'(expWdt()), "wdtStep");
      if (wdtStep) wdtSeen++;
    end
  end

  task automatic nxt(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic wrTimer(input logic [7:0] v);
    timerWrEn = 1'b1; timerWrData = v; nxt(); timerWrEn = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    nxt(3);
    curReq = "R1";
    chk(int'(timerVal), 0, "reset timer");
    chk(int'(ovfFlag), 0, "reset flag");
    chk(int'(ovfEnable), 0, "reset enable");
    rstN = 1'b1; nxt();

    // R3 and R6: tick source, timer owner, ratio 1:2
    curReq = "R3";
    cycleTick = 1'b1; nxt(20); cycleTick = 1'b0; nxt();
    chk(int'(timerVal), 10, "R3 1:2 after 20 ticks");

    // R3: ratio 1:8
    cfgByte = 8'h02; wrTimer(8'h00);
    cycleTick = 1'b1; nxt(64); cycleTick = 1'b0; nxt();
    chk(int'(timerVal), 8, "R3 1:8 after 64 ticks");

    // R8: write clears partial prescaler count
    curReq = "R8";
    cfgByte = 8'h01; wrTimer(8'h00);
    cycleTick = 1'b1; nxt(3); cycleTick = 1'b0;
    wrTimer(8'h05);
    cycleTick = 1'b1; nxt(3); cycleTick = 1'b0; nxt();
    chk(int'(timerVal), 5, "R8 no step after 3 of 4");
    cycleTick = 1'b1; nxt(1); cycleTick = 1'b0; nxt();
    chk(int'(timerVal), 6, "R8 step on 4th event");

    // R4 and R5: watchdog owner, 1:8
    curReq = "R5";
    wdtSeen = 0; wdtBaseTick = 1'b1; nxt(5); wdtBaseTick = 1'b0; nxt();
    chk(wdtSeen, 5, "R5 passthrough count");
    curReq = "R4";
    cfgByte = 8'h0B; nxt();
    wdtSeen = 0; wdtBaseTick = 1'b1; nxt(32); wdtBaseTick = 1'b0; nxt();
    chk(wdtSeen, 4, "R4 wdt 1:8 steps");
    cycleTick = 1'b1; nxt(7); cycleTick = 1'b0; nxt();
    chk(int'(timerVal), 13, "R4 timer direct");

    // R2, R6, R7: external pin, rising, upper cfg bits set
    curReq = "R7";
    cfgByte = 8'hE8; nxt();
    cycleTick = 1'b1;
    for (int k = 0; k < 5; k++) begin
      extPin = 1'b1; nxt(3); extPin = 1'b0; nxt(3);
    end
    cycleTick = 1'b0; nxt(4);
    chk(int'(timerVal), 18, "R7 rising edges, R2 upper bits ignored, R6 tick ignored");
    cfgByte = 8'hF8; nxt(2);
    for (int k = 0; k < 3; k++) begin
      extPin = 1'b1; nxt(3); extPin = 1'b0; nxt(3);
    end
    nxt(4);
    chk(int'(timerVal), 21, "R7 falling edges");

    // R9: rollover and set-wins
    curReq = "R9";
    cfgByte = 8'h08; wrTimer(8'hFE);
    cycleTick = 1'b1; nxt(2); cycleTick = 1'b0; nxt();
    chk(int'(timerVal), 0, "R9 wrap to zero");
    chk(int'(ovfFlag), 1, "R9 flag set");
    nxt(3);
    chk(int'(ovfFlag), 1, "R9 flag held");
    curReq = "R10";
    flagWrEn = 1'b1; flagWrData = 8'h00; nxt(); flagWrEn = 1'b0; nxt();
    chk(int'(ovfFlag), 0, "R10 flag cleared by write");
    curReq = "R9";
    wrTimer(8'hFF);
    cycleTick = 1'b1; flagWrEn = 1'b1; flagWrData = 8'h00; nxt();
    cycleTick = 1'b0; flagWrEn = 1'b0; nxt();
    chk(int'(ovfFlag), 1, "R9 set beats clear");

    // R10: enable write
    curReq = "R10";
    flagWrEn = 1'b1; flagWrData = 8'h20; nxt(); flagWrEn = 1'b0; nxt();
    chk(int'(ovfEnable), 1, "R10 enable set");
    chk(int'(ovfFlag), 0, "R10 flag from bit 2");

    nxt(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule